// File: doc/BRIEF.md
# Memory-Mapped Task-File Decoder

This block sits between the host side of a removable storage card and its ATA task-file logic. It turns each memory-space access into one of two things. A register access gives a canonical register index and a read or write strobe. A data access gives a byte or word pop/push on a sequential data buffer port. The block also routes the right byte lane between the 16-bit host data bus and the 8-bit register path or the buffer word.

The buffer can be reached through several aliases: the primary data offset, two duplicate offsets (one for the even byte, one for the odd byte), and a 1 KB window in the upper half of the address space, where even and odd addresses alias those two duplicates. Every alias shares one byte-ordering state. A host can mix byte and word transfers through any alias and still walk the buffer in order. One access is one clock cycle in which exactly one of the output enable and the write enable is low. Decode and data steering are combinational within that cycle. The byte-ordering state updates at the closing clock edge.

Top module: `tfdec_top`

## Requirements
- R1: No strobe fires and the read bus is not driven unless all three of these hold in the cycle: `reg_sel_n` is high, at least one of `ce_lo_n`/`ce_hi_n` is low, and exactly one of `oe_n`/`we_n` is low.
- R2: With `addr[10]` low, `addr[3:0]` selects the target and `addr[9:4]` are ignored. Offsets 1..7 give `tf_idx` equal to the offset, offset 13 gives index 1, offset 14 gives index 14, and offset 15 gives index 15 on reads only. Offsets 10..12, and offset 15 on a write, decode to nothing. `tf_idx` is 0 whenever no register strobe is active, and at most one of `tf_rd`, `tf_wr`, `buf_rd`, `buf_wr` is high.
- R3: When both enables are low, an access to offset 0 or 1 (`addr[0]` ignored), 8 or 9 is a word transfer. `buf_word` is 1, all 16 bits pass, and the byte state returns to even.
- R4: A byte access to offset 0 with only `ce_hi_n` low goes to register index 1 and not to the buffer.
- R5: Byte accesses to offset 0 or 8 alternate even byte (`buf_odd`=0) then odd byte (`buf_odd`=1). `ptr_odd` is 1 exactly when the next such access takes the odd byte.
- R6: A byte access to offset 9 always moves the odd byte. When it follows an even byte it completes that word. When it starts a word, the next offset-0/8 byte access takes the even byte of the same word and then the state returns to even.
- R7: A byte access to offset 9 right after another offset-9 byte access with no even byte between them raises `seq_err`. That cycle has no strobe and no bus drive, and the byte state is left unchanged.
- R8: With `addr[10]` high, `addr[9:1]` are ignored. An even address acts as offset 8 and an odd address acts as offset 9.
- R9: `host_rdrv` is high exactly on a decoded read. A byte read lands on bits 7..0 when `ce_lo_n` is low and on bits 15..8 when only `ce_hi_n` is low, with the other half zero. A word buffer read returns the whole buffer word. `host_rdata` is 0 when not driving.
- R10: On writes, the byte taken is bits 7..0 when `ce_lo_n` is low, otherwise bits 15..8. `tf_wdata` carries that byte only on `tf_wr`. `buf_wdata` carries the full word on word writes and the byte copied into both halves on byte writes, and is 0 otherwise.
- R11: A synchronous reset returns the byte state to even, so `ptr_odd` is 0 and a following offset-9 byte access does not raise `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel_n | input | 1 | Register-space select; must be high for task-file decoding |
| addr | input | 11 | Host address A10..A0 |
| ce_lo_n | input | 1 | Active-low low-byte enable |
| ce_hi_n | input | 1 | Active-low high-byte enable |
| oe_n | input | 1 | Active-low output (read) enable |
| we_n | input | 1 | Active-low write enable |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdrv | output | 1 | Drive enable for the host data bus |
| tf_idx | output | 4 | Canonical task-file register index |
| tf_rd | output | 1 | Task-file register read strobe |
| tf_wr | output | 1 | Task-file register write strobe |
| tf_wdata | output | 8 | Byte written to the task-file register |
| tf_rdata | input | 8 | Byte read from the selected task-file register |
| buf_rd | output | 1 | Data buffer pop |
| buf_wr | output | 1 | Data buffer push |
| buf_word | output | 1 | Pop/push is a whole 16-bit word |
| buf_odd | output | 1 | Byte pop/push uses the odd byte of the word |
| buf_wdata | output | 16 | Data pushed to the buffer |
| buf_rdata | input | 16 | Word at the buffer head |
| ptr_odd | output | 1 | Next offset-0/8 byte access takes the odd byte |
| seq_err | output | 1 | Unsupported repeated odd-port byte access |

## Verification
The bench goes after the cases where the aliases meet. Suppose offset 1 under a word access were decoded as the error register: word reads with `addr[0]` set would go to the task file and leave the buffer alone. If the high-enable-only byte at offset 0 went to the buffer, feature writes would corrupt the data stream. If the odd-first order were not remembered, a 9-then-8 pair would move the odd byte twice or skip the even byte. If a repeated odd access advanced the state, every later byte would be off by one. The bench also drives mixed word/byte sequences, window addresses with junk in the middle bits, and a reset in mid-word. A design that forgot to realign on a word, or to clear the state on reset, would then put the next byte on the wrong lane.

// File: rtl/tfdec_pkg.sv
package tfdec_pkg;
    localparam int IDXW = 4;

    typedef enum logic [1:0] {
        PTR_EVEN = 2'd0,
        PTR_ODD  = 2'd1,
        PTR_TAIL = 2'd2
    } ptr_e;

    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_REG       = 2'd1,
        ACC_DATA_EVEN = 2'd2,
        ACC_DATA_ODD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e            kind;
        logic [IDXW-1:0] idx;
    } dec_s;

    typedef struct packed {
        ptr_e ptr;
    } seq_s;
endpackage

// File: rtl/tfdec_decode.sv
module tfdec_decode
    import tfdec_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr,
    input  logic          access_ok,
    input  logic          is_read,
    input  logic          wide,
    input  logic          hi_only,
    output dec_s          dec
);
    localparam int OFFW = 4;

    logic            win;
    logic [OFFW-1:0] off;
    logic            unused_mid;

    assign win        = addr[AW-1];
    assign off        = win ? {3'b100, addr[0]} : addr[OFFW-1:0];
    assign unused_mid = ^addr[AW-2:OFFW];

    always_comb begin
        dec.kind = ACC_NONE;
        dec.idx  = '0;
        if (access_ok) begin
            if (!win && wide && off[OFFW-1:1] == '0) begin
                dec.kind = ACC_DATA_EVEN;
            end else begin
                case (off)
                    4'h0: begin
                        if (hi_only) begin
                            dec.kind = ACC_REG;
                            dec.idx  = IDXW'(1);
                        end else begin
                            dec.kind = ACC_DATA_EVEN;
                        end
                    end
                    4'h8: dec.kind = ACC_DATA_EVEN;
                    4'h9: dec.kind = ACC_DATA_ODD;
                    4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hE: begin
                        dec.kind = ACC_REG;
                        dec.idx  = off;
                    end
                    4'hD: begin
                        dec.kind = ACC_REG;
                        dec.idx  = IDXW'(1);
                    end
                    4'hF: begin
                        if (is_read) begin
                            dec.kind = ACC_REG;
                            dec.idx  = off;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tfdec_byteseq.sv
module tfdec_byteseq
    import tfdec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic word,
    input  logic odd_port,
    output logic lane_odd,
    output logic err,
    output logic ptr_odd
);
    seq_s seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        lane_odd = 1'b0;
        err      = 1'b0;
        if (go) begin
            if (word) begin
                seq_d.ptr = PTR_EVEN;
            end else if (!odd_port) begin
                case (seq_q.ptr)
                    PTR_EVEN: seq_d.ptr = PTR_ODD;
                    PTR_ODD: begin
                        lane_odd  = 1'b1;
                        seq_d.ptr = PTR_EVEN;
                    end
                    default: seq_d.ptr = PTR_EVEN;
                endcase
            end else begin
                case (seq_q.ptr)
                    PTR_TAIL: err = 1'b1;
                    PTR_ODD: begin
                        lane_odd  = 1'b1;
                        seq_d.ptr = PTR_EVEN;
                    end
                    default: begin
                        lane_odd  = 1'b1;
                        seq_d.ptr = PTR_TAIL;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '{ptr: PTR_EVEN};
        else     seq_q <= seq_d;
    end

    assign ptr_odd = (seq_q.ptr == PTR_ODD);

    // R7
    repeat_odd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !rst) |=> (seq_q.ptr == $past(seq_q.ptr)));

    // R3
    word_realign_chk: assert property (@(posedge clk) disable iff (rst)
        (go && word && !rst) |=> (seq_q.ptr == PTR_EVEN));

    // R6
    odd_first_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !word && odd_port && seq_q.ptr == PTR_EVEN && !rst) |=> (seq_q.ptr == PTR_TAIL));
endmodule

// File: rtl/tfdec_lanes.sv
module tfdec_lanes #(
    parameter int DW = 16
) (
    input  logic          lo_sel,
    input  logic          is_reg,
    input  logic          lane_odd,
    input  logic          word_xfer,
    input  logic          drive,
    input  logic          tf_wen,
    input  logic          buf_wen,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] buf_rdata,
    input  logic [DW/2-1:0] tf_rdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW/2-1:0] tf_wdata,
    output logic [DW-1:0] buf_wdata
);
    localparam int BW = DW / 2;

    logic [BW-1:0] rd_byte;
    logic [BW-1:0] wr_byte;
    logic [BW-1:0] buf_lane [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign buf_lane[g] = buf_rdata[g*BW +: BW];
    end

    assign rd_byte = is_reg ? tf_rdata : buf_lane[lane_odd];
    assign wr_byte = lo_sel ? host_wdata[BW-1:0] : host_wdata[DW-1:BW];

    always_comb begin
        host_rdata = '0;
        if (drive) begin
            if (word_xfer)   host_rdata = buf_rdata;
            else if (lo_sel) host_rdata = {{BW{1'b0}}, rd_byte};
            else             host_rdata = {rd_byte, {BW{1'b0}}};
        end
    end

    assign tf_wdata  = tf_wen ? wr_byte : '0;
    assign buf_wdata = !buf_wen ? '0 : (word_xfer ? host_wdata : {wr_byte, wr_byte});
endmodule

// File: rtl/tfdec_top.sv
module tfdec_top
    import tfdec_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_sel_n,
    input  logic [AW-1:0]   addr,
    input  logic            ce_lo_n,
    input  logic            ce_hi_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            host_rdrv,
    output logic [3:0]      tf_idx,
    output logic            tf_rd,
    output logic            tf_wr,
    output logic [DW/2-1:0] tf_wdata,
    input  logic [DW/2-1:0] tf_rdata,
    output logic            buf_rd,
    output logic            buf_wr,
    output logic            buf_word,
    output logic            buf_odd,
    output logic [DW-1:0]   buf_wdata,
    input  logic [DW-1:0]   buf_rdata,
    output logic            ptr_odd,
    output logic            seq_err
);
    logic access_ok, is_read, wide, hi_only;
    logic is_data, is_reg, lane_odd, err, buf_go;
    dec_s dec;

    assign wide      = !ce_lo_n && !ce_hi_n;
    assign hi_only   = ce_lo_n && !ce_hi_n;
    assign is_read   = !oe_n;
    assign access_ok = reg_sel_n && (!ce_lo_n || !ce_hi_n) && (oe_n != we_n);

    tfdec_decode #(.AW(AW)) u_dec (
        .addr(addr), .access_ok(access_ok), .is_read(is_read),
        .wide(wide), .hi_only(hi_only), .dec(dec)
    );

    assign is_data = (dec.kind == ACC_DATA_EVEN) || (dec.kind == ACC_DATA_ODD);
    assign is_reg  = (dec.kind == ACC_REG);

    tfdec_byteseq u_seq (
        .clk(clk), .rst(rst), .go(is_data), .word(wide),
        .odd_port(dec.kind == ACC_DATA_ODD),
        .lane_odd(lane_odd), .err(err), .ptr_odd(ptr_odd)
    );

    assign buf_go    = is_data && !err;
    assign buf_rd    = buf_go && is_read;
    assign buf_wr    = buf_go && !is_read;
    assign buf_word  = buf_go && wide;
    assign buf_odd   = buf_go && !wide && lane_odd;
    assign tf_rd     = is_reg && is_read;
    assign tf_wr     = is_reg && !is_read;
    assign tf_idx    = is_reg ? dec.idx : '0;
    assign host_rdrv = tf_rd || buf_rd;
    assign seq_err   = err;

    tfdec_lanes #(.DW(DW)) u_lanes (
        .lo_sel(!ce_lo_n), .is_reg(is_reg), .lane_odd(lane_odd),
        .word_xfer(buf_word), .drive(host_rdrv), .tf_wen(tf_wr),
        .buf_wen(buf_wr), .host_wdata(host_wdata), .buf_rdata(buf_rdata),
        .tf_rdata(tf_rdata), .host_rdata(host_rdata), .tf_wdata(tf_wdata),
        .buf_wdata(buf_wdata)
    );

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel_n |-> !(tf_rd || tf_wr || buf_rd || buf_wr || host_rdrv));

    // R2
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tf_rd, tf_wr, buf_rd, buf_wr}));

    // R9
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !host_rdrv);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> !(buf_rd || buf_wr || host_rdrv));
endmodule

// File: tb/tfdec_top_test.sv
module tfdec_top_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel_n = 1'b1;
    logic [10:0] addr = '0;
    logic        ce_lo_n = 1'b1, ce_hi_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rdrv;
    logic [3:0]  tf_idx;
    logic        tf_rd, tf_wr;
    logic [7:0]  tf_wdata;
    logic [7:0]  tf_rdata = '0;
    logic        buf_rd, buf_wr, buf_word, buf_odd;
    logic [15:0] buf_wdata;
    logic [15:0] buf_rdata = '0;
    logic        ptr_odd, seq_err;

    int checks = 0;
    int fails  = 0;
    int ps     = 0;
    int seq_n  = 0;

    always #(PERIOD/2) clk = ~clk;

    tfdec_top uut (
        .clk(clk), .rst(rst), .reg_sel_n(reg_sel_n), .addr(addr),
        .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n), .we_n(we_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdrv(host_rdrv),
        .tf_idx(tf_idx), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata),
        .tf_rdata(tf_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr),
        .buf_word(buf_word), .buf_odd(buf_odd), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .ptr_odd(ptr_odd), .seq_err(seq_err)
    );

    function automatic logic [52:0] model(output int nps);
        bit ok, rd, wide, data, oddp, lane, err;
        bit drv, trd, twr, brd, bwr, bw, bo;
        int off, ridx;
        logic [7:0]  rb, wb, twd;
        logic [15:0] rdat, bwd;
        logic [3:0]  tidx;
        ok   = reg_sel_n && (!ce_lo_n || !ce_hi_n) && (oe_n != we_n);
        rd   = !oe_n;
        wide = !ce_lo_n && !ce_hi_n;
        off  = addr[10] ? 8 + int'(addr[0]) : int'(addr[3:0]);
        data = 0; oddp = 0; ridx = -1; nps = ps; lane = 0; err = 0;
        drv = 0; trd = 0; twr = 0; brd = 0; bwr = 0; bw = 0; bo = 0;
        rb = 0; twd = 0; rdat = 0; bwd = 0; tidx = 0;
        if (ok) begin
            if (!addr[10] && wide && off < 2) data = 1;
            else if (off == 0) begin
                if (ce_lo_n) ridx = 1; else data = 1;
            end
            else if (off == 8) data = 1;
            else if (off == 9) begin data = 1; oddp = 1; end
            else if (off < 8) ridx = off;
            else if (off == 13) ridx = 1;
            else if (off == 14) ridx = 14;
            else if (off == 15 && rd) ridx = 15;
        end
        wb = ce_lo_n ? host_wdata[15:8] : host_wdata[7:0];
        if (ridx >= 0) begin
            trd = rd; twr = !rd; tidx = 4'(ridx);
            if (rd) rb = tf_rdata; else twd = wb;
        end
        if (data) begin
            if (wide) nps = 0;
            else if (!oddp) begin
                lane = (ps == 1);
                nps  = (ps == 0) ? 1 : 0;
            end else if (ps == 2) err = 1;
            else begin
                lane = 1;
                nps  = (ps == 1) ? 0 : 2;
            end
            if (!err) begin
                brd = rd; bwr = !rd; bw = wide; bo = !wide && lane;
                if (rd) rb = lane ? buf_rdata[15:8] : buf_rdata[7:0];
                else bwd = wide ? host_wdata : {wb, wb};
            end
        end
        drv = trd || brd;
        if (drv) rdat = (wide && data) ? buf_rdata : (ce_lo_n ? {rb, 8'h00} : {8'h00, rb});
        return {drv, rdat, trd, twr, tidx, twd, brd, bwr, bw, bo, bwd, err, 1'(ps == 1)};
    endfunction

    task automatic acc(string tag, bit rs, logic [10:0] a, bit c1n, bit c2n,
                       bit rd, bit wr, logic [15:0] wd);
        logic [52:0] exp_v, act_v;
        int nps;
        @(posedge clk);
        #1;
        reg_sel_n = rs; addr = a; ce_lo_n = c1n; ce_hi_n = c2n;
        oe_n = !rd; we_n = !wr; host_wdata = wd;
        seq_n++;
        buf_rdata = {8'hB0 ^ 8'(seq_n), 8'h40 + 8'(seq_n)};
        tf_rdata  = 8'hC3 ^ 8'(seq_n * 7);
        exp_v = model(nps);
        @(negedge clk);
        act_v = {host_rdrv, host_rdata, tf_rd, tf_wr, tf_idx, tf_wdata,
                 buf_rd, buf_wr, buf_word, buf_odd, buf_wdata, seq_err, ptr_odd};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
        ps = nps;
    endtask

    task automatic idle(string tag);
        acc(tag, 1'b1, 11'h000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; oe_n = 1'b1; we_n = 1'b1; ce_lo_n = 1'b1; ce_hi_n = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        ps = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        ps = 0;
        // R11: reset state
        idle("R11 reset idle");

        // R1: gating
        acc("R1 reg space", 1'b0, 11'h002, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R1 no enable", 1'b1, 11'h008, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R1 both strobes", 1'b1, 11'h008, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234);
        acc("R1 reg space write", 1'b0, 11'h008, 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234);

        // R2: register map, middle bits ignored
        for (int i = 1; i < 16; i++) begin
            acc("R2 reg read", 1'b1, {1'b0, 6'(i * 11), 4'(i)}, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
            if (i != 8 && i != 9)
                acc("R2 reg write", 1'b1, {1'b0, 6'h3F, 4'(i)}, 1'b0, 1'b1, 1'b0, 1'b1, 16'hA000 + 16'(i));
        end
        acc("R2 offset F write miss", 1'b1, 11'h00F, 1'b0, 1'b1, 1'b0, 1'b1, 16'h55AA);

        // R3: word transfers, A0 ignored
        acc("R3 word read 0", 1'b1, 11'h000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R3 word read 1", 1'b1, 11'h001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R3 word read 8", 1'b1, 11'h1F8, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R3 word write 9", 1'b1, 11'h009, 1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        acc("R3 byte before word", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R3 word realigns", 1'b1, 11'h008, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R3 even after word", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R3 odd tail", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R3 odd-first then word", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R3 word from tail", 1'b1, 11'h000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);
        idle("R3 idle even");

        // R4: high-enable-only byte at offset 0
        acc("R4 error read", 1'b1, 11'h000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R4 features write", 1'b1, 11'h000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h7E11);
        idle("R4 state untouched");

        // R5: sequential bytes through 0 and 8
        acc("R5 byte 0 even", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R5 byte 0 odd", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R5 byte 8 even", 1'b1, 11'h008, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R5 byte 0 odd mix", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R5 byte 8 write even", 1'b1, 11'h008, 1'b0, 1'b1, 1'b0, 1'b1, 16'h3344);
        acc("R5 byte 8 write odd", 1'b1, 11'h008, 1'b0, 1'b1, 1'b0, 1'b1, 16'h5566);

        // R6: odd port orderings
        acc("R6 8 then", 1'b1, 11'h008, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R6 9 completes", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R6 9 first", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R6 then 8 even", 1'b1, 11'h008, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R6 back to even", 1'b1, 11'h008, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R6 9 after even", 1'b1, 11'h009, 1'b0, 1'b1, 1'b0, 1'b1, 16'h9A9B);

        // R7: repeated odd port
        acc("R7 first 9", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R7 repeat 9", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R7 repeat 9 write", 1'b1, 11'h009, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1111);
        acc("R7 even still pending", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        idle("R7 idle even");

        // R8: window streaming with incrementing addresses
        for (int a = 11'h400; a < 11'h40C; a++)
            acc("R8 window byte", 1'b1, 11'(a), 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        acc("R8 window junk even", 1'b1, 11'h7AE, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00C7);
        acc("R8 window junk odd", 1'b1, 11'h5F3, 1'b0, 1'b1, 1'b0, 1'b1, 16'h00D8);
        acc("R8 window word", 1'b1, 11'h7FF, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

        // R9: lane placement on reads
        acc("R9 hi lane byte 8", 1'b1, 11'h008, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R9 hi lane byte 8 odd", 1'b1, 11'h008, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R9 hi lane register", 1'b1, 11'h003, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
        acc("R9 word register read", 1'b1, 11'h002, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0);

        // R10: write steering
        acc("R10 hi byte reg write", 1'b1, 11'h004, 1'b1, 1'b0, 1'b0, 1'b1, 16'hE1F2);
        acc("R10 hi byte buf write", 1'b1, 11'h408, 1'b1, 1'b0, 1'b0, 1'b1, 16'h7A01);
        acc("R10 word buf write", 1'b1, 11'h000, 1'b0, 1'b0, 1'b0, 1'b1, 16'hC0DE);

        // R11: reset in mid-word
        acc("R11 byte before reset", 1'b1, 11'h000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        do_reset();
        idle("R11 after reset even");
        acc("R11 odd-first", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        do_reset();
        acc("R11 no error after reset", 1'b1, 11'h009, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0);
        idle("R11 final idle");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule